// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Engine

This block takes a reference frequency and a wanted output frequency, both in kHz. It searches for the feedback multiplier M, the input divider D and the output divider DOUT of a phase-locked clock synthesizer. The frequency at the phase detector (fin/D) and at the oscillator (fin·M/D) must both stay inside fixed windows. From the candidates that meet those limits, the block keeps the one whose output is nearest the target.

The search is a multi-cycle state machine. M is the outer loop and runs upwards. D is the inner loop and also runs upwards. For each M the D range is narrowed to the values that keep the oscillator in its window. One shared restoring divider, which produces one quotient bit per cycle, does every division: the limit computations, the oscillator frequency, the rounding of DOUT and the achieved frequency. The search stops at once when a candidate hits the target exactly.

A request is a single-beat valid/ready transfer. `req_ready` is high only while the engine is idle. A `req_valid` seen while `req_ready` is low is dropped and is not queued. The result has no back-pressure. `done` pulses for one cycle, and the result ports are valid in that cycle.

Top module: `clksynth_search`

## Requirements
- R1: After reset, `req_ready` is 1 and `done` and `not_found` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. A `req_valid` raised while the engine is busy is ignored: it produces no extra `done`, and the running search completes with its own result.
- R3: D starts at the larger of ceil(fin/300000) and 1, and stops at the smaller of floor(fin/10000) and 80. For each M, D is further limited to the range ceil(fin·M/1200000) through floor(fin·M/600000).
- R4: For each candidate, DOUT is the oscillator frequency fin·M/D (truncated) divided by the target and rounded to the nearest integer. A half rounds up. DOUT is then clamped to the range 1 to 128.
- R5: The achieved frequency reported for a candidate is the oscillator frequency divided by DOUT, truncated.
- R6: M runs from max(ceil(600000/fin)·Dmin, 1) up to min(floor(1200000·Dmax/fin), 64). M is the outer loop and D the inner loop, both ascending. A candidate replaces the best so far only if its absolute error is strictly smaller, so on a tie the earlier candidate is kept.
- R7: The search ends as soon as a candidate's achieved frequency equals the target. That candidate is the result.
- R8: If no candidate is evaluated, `not_found` is 1 with `done`, and M, D, DOUT and the achieved frequency read 0. This includes the case where fin or fout is 0.
- R9: `done` is high for exactly one cycle, and `req_ready` is high in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle, request accepted |
| req_fin_khz | input | FREQ_W | Reference frequency, kHz |
| req_fout_khz | input | FREQ_W | Target output frequency, kHz |
| done | output | 1 | One-cycle result strobe |
| not_found | output | 1 | With done: no candidate existed |
| res_m | output | 7 | Best feedback multiplier |
| res_d | output | 7 | Best input divider |
| res_dout | output | 8 | Best output divider |
| res_freq_khz | output | FREQ_W+8 | Achieved output frequency, kHz |

## Verification
A bad loop limit or a corrupted best-so-far register shows at the ports only when `done` pulses. Until then the divider values are all internal, which can be thousands of cycles after the request. Such a fault appears as an M, D or DOUT that differs from an independent software search, or as a `done` that comes too early or too late. A fault in the exact-match exit or the tie rule can leave the achieved frequency correct while M or D differ. For that reason all four result fields and the flag are compared on every result. The request handshake fails faster: a busy engine that restarts shows as a missing or extra `done`.

// File: rtl/clksynth_pkg.sv
package clksynth_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DMIN, ST_DMAX, ST_MMUL, ST_MMAX,
    ST_DLO, ST_DHI, ST_VCO, ST_DOUT, ST_FOUT, ST_DONE
  } srch_state_e;
endpackage

// File: rtl/clksynth_divider.sv
module clksynth_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quot,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem, q, den_r;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    trial, diff;
  logic          ge;

  assign trial = {rem, q[W-1]};
  assign diff  = trial - {1'b0, den_r};
  assign ge    = trial >= {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      q     <= '0;
      den_r <= '0;
      cnt   <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= '0;
        q     <= num;
        den_r <= den;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff[W-1:0] : trial[W-1:0];
        q   <= {q[W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = q;

  // R5: the shared divider is never restarted mid-division
  assert_issue_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run);
  // R5: a quotient strobe only follows an active division
  assert_done_after_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(run));
endmodule

// File: rtl/clksynth_best.sv
module clksynth_best #(
  parameter int FW      = 32,
  parameter int M_W     = 7,
  parameter int D_W     = 7,
  parameter int O_W     = 8,
  parameter int O_MAX   = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           cand_valid,
  input  logic [FW-1:0]  cand_f,
  input  logic [FW-1:0]  target,
  input  logic [M_W-1:0] cand_m,
  input  logic [D_W-1:0] cand_d,
  input  logic [O_W-1:0] cand_o,
  output logic           have,
  output logic [M_W-1:0] best_m,
  output logic [D_W-1:0] best_d,
  output logic [O_W-1:0] best_o,
  output logic [FW-1:0]  best_f
);
  logic [FW-1:0] err, best_err;
  logic          take;

  assign err  = (cand_f >= target) ? cand_f - target : target - cand_f;
  assign take = cand_valid && (!have || err < best_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0; best_m <= '0; best_d <= '0; best_o <= '0;
      best_f <= '0; best_err <= '0;
    end else if (clear) begin
      have <= 1'b0; best_m <= '0; best_d <= '0; best_o <= '0;
      best_f <= '0; best_err <= '0;
    end else if (take) begin
      have     <= 1'b1;
      best_m   <= cand_m;
      best_d   <= cand_d;
      best_o   <= cand_o;
      best_f   <= cand_f;
      best_err <= err;
    end
  end

  // R6: the kept error never grows within one search
  assert_err_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (have && !clear) |=> (best_err <= $past(best_err)));
  // R4: a kept divider is always inside the clamp range
  assert_dout_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (best_o >= O_W'(1) && best_o <= O_W'(O_MAX)));
endmodule

// File: rtl/clksynth_search.sv
module clksynth_search
  import clksynth_pkg::*;
#(
  parameter int FREQ_W   = 24,
  parameter int PFD_MIN  = 10000,
  parameter int PFD_MAX  = 300000,
  parameter int VCO_MIN  = 600000,
  parameter int VCO_MAX  = 1200000,
  parameter int D_CAP    = 80,
  parameter int M_CAP    = 64,
  parameter int DOUT_CAP = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [FREQ_W-1:0]    req_fin_khz,
  input  logic [FREQ_W-1:0]    req_fout_khz,
  output logic                 done,
  output logic                 not_found,
  output logic [6:0]           res_m,
  output logic [6:0]           res_d,
  output logic [7:0]           res_dout,
  output logic [FREQ_W+7:0]    res_freq_khz
);
  localparam int WIDE_W = FREQ_W + 8;
  localparam int M_W    = $clog2(M_CAP + 1);
  localparam int D_W    = $clog2(D_CAP + 1);
  localparam int O_W    = $clog2(DOUT_CAP + 1);
  localparam logic [WIDE_W-1:0] K_ONE  = WIDE_W'(1);
  localparam logic [WIDE_W-1:0] K_PMIN = WIDE_W'(PFD_MIN);
  localparam logic [WIDE_W-1:0] K_PMAX = WIDE_W'(PFD_MAX);
  localparam logic [WIDE_W-1:0] K_VMIN = WIDE_W'(VCO_MIN);
  localparam logic [WIDE_W-1:0] K_VMAX = WIDE_W'(VCO_MAX);
  localparam logic [WIDE_W-1:0] K_DCAP = WIDE_W'(D_CAP);
  localparam logic [WIDE_W-1:0] K_MCAP = WIDE_W'(M_CAP);
  localparam logic [WIDE_W-1:0] K_OCAP = WIDE_W'(DOUT_CAP);

  function automatic logic [WIDE_W-1:0] wmax(input logic [WIDE_W-1:0] a, input logic [WIDE_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
  function automatic logic [WIDE_W-1:0] wmin(input logic [WIDE_W-1:0] a, input logic [WIDE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  srch_state_e       state;
  logic              issued;
  logic [WIDE_W-1:0] fin_r, fout_r, dmin, dmax, mmax, dhi, m, d, fvco, dout_c;
  logic [WIDE_W-1:0] fin_m, num, den, quot, mm_prod, mmax_new, dhi_new;
  logic              div_start, div_done, is_div, have;

  assign fin_m     = fin_r * m;
  assign mm_prod   = quot * dmin;
  assign mmax_new  = wmin(quot, K_MCAP);
  assign dhi_new   = wmin(dmax, quot);
  assign is_div    = (state != ST_IDLE) && (state != ST_DONE);
  assign div_start = is_div && !issued;

  always_comb begin
    num = '0;
    den = K_ONE;
    case (state)
      ST_DMIN: begin num = fin_r + K_PMAX - K_ONE;  den = K_PMAX; end
      ST_DMAX: begin num = fin_r;                   den = K_PMIN; end
      ST_MMUL: begin num = K_VMIN + fin_r - K_ONE;  den = fin_r;  end
      ST_MMAX: begin num = K_VMAX * dmax;           den = fin_r;  end
      ST_DLO:  begin num = fin_m + K_VMAX - K_ONE;  den = K_VMAX; end
      ST_DHI:  begin num = fin_m;                   den = K_VMIN; end
      ST_VCO:  begin num = fin_m;                   den = d;      end
      ST_DOUT: begin num = fvco + (fout_r >> 1);    den = fout_r; end
      ST_FOUT: begin num = fvco;                    den = dout_c; end
      default: ;
    endcase
  end

  clksynth_divider #(.W(WIDE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(num), .den(den), .quot(quot), .done(div_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; issued <= 1'b0;
      fin_r <= '0; fout_r <= '0; dmin <= '0; dmax <= '0; mmax <= '0;
      dhi <= '0; m <= '0; d <= '0; fvco <= '0; dout_c <= '0;
    end else begin
      if (div_start) issued <= 1'b1;
      if (div_done)  issued <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          fin_r  <= WIDE_W'(req_fin_khz);
          fout_r <= WIDE_W'(req_fout_khz);
          state  <= (req_fin_khz == '0 || req_fout_khz == '0) ? ST_DONE : ST_DMIN;
        end
        ST_DMIN: if (div_done) begin dmin <= wmax(quot, K_ONE);   state <= ST_DMAX; end
        ST_DMAX: if (div_done) begin dmax <= wmin(quot, K_DCAP);  state <= ST_MMUL; end
        ST_MMUL: if (div_done) begin m <= wmax(mm_prod, K_ONE);   state <= ST_MMAX; end
        ST_MMAX: if (div_done) begin
          mmax  <= mmax_new;
          state <= (m > mmax_new) ? ST_DONE : ST_DLO;
        end
        ST_DLO:  if (div_done) begin d <= wmax(dmin, quot); state <= ST_DHI; end
        ST_DHI:  if (div_done) begin
          dhi <= dhi_new;
          if (d <= dhi_new)      state <= ST_VCO;
          else if (m >= mmax)    state <= ST_DONE;
          else begin m <= m + K_ONE; state <= ST_DLO; end
        end
        ST_VCO:  if (div_done) begin fvco <= quot; state <= ST_DOUT; end
        ST_DOUT: if (div_done) begin
          dout_c <= wmin(wmax(quot, K_ONE), K_OCAP);
          state  <= ST_FOUT;
        end
        ST_FOUT: if (div_done) begin
          if (quot == fout_r)    state <= ST_DONE;
          else if (d < dhi)      begin d <= d + K_ONE; state <= ST_VCO; end
          else if (m >= mmax)    state <= ST_DONE;
          else begin m <= m + K_ONE; state <= ST_DLO; end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  clksynth_best #(.FW(WIDE_W), .M_W(M_W), .D_W(D_W), .O_W(O_W), .O_MAX(DOUT_CAP)) u_best (
    .clk(clk), .rst_n(rst_n),
    .clear(state == ST_IDLE && req_valid),
    .cand_valid(state == ST_FOUT && div_done),
    .cand_f(quot), .target(fout_r),
    .cand_m(m[M_W-1:0]), .cand_d(d[D_W-1:0]), .cand_o(dout_c[O_W-1:0]),
    .have(have), .best_m(res_m), .best_d(res_d), .best_o(res_dout),
    .best_f(res_freq_khz)
  );

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign not_found = done && !have;

  // R9: result strobe lasts one cycle and the engine is idle afterwards
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_after_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R2: a busy engine never returns to idle without a result strobe
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !done) |=> !req_ready);
  // R3: every evaluated candidate lies inside the caps
  assert_loop_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VCO) |-> (d >= K_ONE && d <= K_DCAP && m >= K_ONE && m <= K_MCAP));
  // R8: an empty search reports zero dividers
  assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    not_found |-> (res_m == '0 && res_d == '0 && res_dout == '0 && res_freq_khz == '0));
endmodule

// File: tb/clksynth_search_tb_top.sv
module clksynth_search_tb_top;
  localparam int FREQ_W = 24;

  typedef struct {
    longint m, d, o, f, fin, fout;
    bit     nf, exact;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid, req_ready, done, not_found;
  logic [FREQ_W-1:0] req_fin, req_fout;
  logic [6:0]        res_m, res_d;
  logic [7:0]        res_dout;
  logic [FREQ_W+7:0] res_freq;

  int   checks = 0, fails = 0;
  bit   prev_done = 1'b0;
  exp_t sbq[$];

  always #4 clk = ~clk;

  clksynth_search dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fin_khz(req_fin), .req_fout_khz(req_fout), .done(done),
    .not_found(not_found), .res_m(res_m), .res_d(res_d), .res_dout(res_dout),
    .res_freq_khz(res_freq)
  );

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(longint fin, longint fout);
    exp_t e;
    longint dmin, dmax, mmin, mmax, berr;
    bit have, stop;
    e = '{m:0, d:0, o:0, f:0, fin:fin, fout:fout, nf:1'b1, exact:1'b0};
    have = 0; stop = 0; berr = 0;
    if (fin == 0 || fout == 0) return e;
    dmin = (fin + 299999) / 300000; if (dmin < 1) dmin = 1;
    dmax = fin / 10000;             if (dmax > 80) dmax = 80;
    mmin = ((600000 + fin - 1) / fin) * dmin; if (mmin < 1) mmin = 1;
    mmax = 1200000 * dmax / fin;    if (mmax > 64) mmax = 64;
    for (longint m = mmin; m <= mmax && !stop; m++) begin
      longint lo, hi;
      lo = (fin * m + 1199999) / 1200000; if (lo < dmin) lo = dmin;
      hi = fin * m / 600000;              if (hi > dmax) hi = dmax;
      for (longint d = lo; d <= hi && !stop; d++) begin
        longint vco, o, f, err;
        vco = fin * m / d;
        o = (vco + fout / 2) / fout;
        if (o < 1) o = 1;
        if (o > 128) o = 128;
        f = vco / o;
        err = (f >= fout) ? f - fout : fout - f;
        if (!have || err < berr) begin
          have = 1; berr = err;
          e.m = m; e.d = d; e.o = o; e.f = f; e.nf = 0;
          if (err == 0) begin e.exact = 1; stop = 1; end
        end
      end
    end
    return e;
  endfunction

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        check(done == 1'b0, "R9 done lasts one cycle", longint'(done), 0);
        check(req_ready == 1'b1, "R9 ready after done", longint'(req_ready), 1);
      end
      prev_done = done;
      if (done) begin
        if (sbq.size() == 0) check(1'b0, "R2 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          check(longint'(res_m) == e.m, "R6 M", longint'(res_m), e.m);
          check(longint'(res_d) == e.d, "R3 D", longint'(res_d), e.d);
          check(longint'(res_dout) == e.o, "R4 DOUT", longint'(res_dout), e.o);
          check(longint'(res_freq) == e.f, "R5 freq", longint'(res_freq), e.f);
          check(not_found == e.nf, "R8 not_found", longint'(not_found), longint'(e.nf));
          if (e.exact)
            check(longint'(res_freq) == e.fout, "R7 exact stop", longint'(res_freq), e.fout);
        end
      end
    end
  end

  // driver: push expected, then hand the request over
  task automatic send(longint fin, longint fout);
    while (!req_ready) @(negedge clk);
    sbq.push_back(model(fin, fout));
    req_valid = 1'b1;
    req_fin   = FREQ_W'(fin);
    req_fout  = FREQ_W'(fout);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_fin = '0; req_fout = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", longint'(req_ready), 1);
    check(done == 1'b0, "R1 done after reset", longint'(done), 0);
    check(not_found == 1'b0, "R1 not_found after reset", longint'(not_found), 0);

    // R2: a second request while busy is dropped
    send(100000, 148500);
    check(req_ready == 1'b0, "R2 busy after accept", longint'(req_ready), 0);
    req_valid = 1'b1; req_fin = FREQ_W'(25000); req_fout = FREQ_W'(100000);
    @(negedge clk);
    req_valid = 1'b0;
    drain();

    send(100000, 100000);  drain();   // R7 exact on first candidate
    send(25000, 148500);   drain();   // R6 narrow D range
    send(27000, 74250);    drain();
    send(50000, 5000000);  drain();   // R4 clamp to 1
    send(50000, 1);        drain();   // R4 clamp to 128
    send(5000, 1000);      drain();   // R8 empty D range
    send(0, 100);          drain();   // R8 zero input
    send(20000, 0);        drain();   // R8 zero target
    send(300001, 123456);  drain();   // R3 Dmin above 1

    summary();
    $finish;
  end
endmodule